// File: doc/BRIEF.md
# UART Modem Control and Loopback Unit

This block holds the modem control register of a 16450-class serial port and everything that hangs directly off it. It drives the outgoing serial pin, the active-low request-to-send and terminal-ready outputs, a reset line for an external device and a power-down request. It selects the serial input that the receiver sees, and it produces the modem status byte, including the sticky change flags that software clears by reading it.

A diagnostic loopback mode turns the port back on itself. The transmit shifter output feeds the receiver. The outgoing pin rests at mark and both modem outputs are released. The four modem status inputs are replaced by the modem control bits, so software sees its own writes in the status byte.

Two extra features take effect only while an enable bit from the interrupt enable register is high: a software-driven external reset and a power-down request. With that enable low, the same control bits are plain storage. Baud timing, the shift registers and the bus decode are outside this block.

Top module: `uart_modem_ctl`

## Requirements
- R1: A hardware reset clears the control register to 0x00, leaves loopback off and holds rts_n and dtr_n high. A write stores the full byte, and the byte is visible on mcr_q after the write edge.
- R2: With loopback off (mcr bit 4 = 0), tx_pin follows tsr_sout, rx_sin follows rx_pin, rts_n is the inverse of mcr bit 1 and dtr_n is the inverse of mcr bit 0.
- R3: With loopback on (mcr bit 4 = 1), tx_pin is 1, rts_n and dtr_n are 1 whatever the control bits hold, and rx_sin follows tsr_sout.
- R4: With loopback on, msr bits 4, 5, 6 and 7 take mcr bits 1, 0, 2 and 3 one clock later, and the external cts_n, dsr_n, ri_n and dcd_n are ignored.
- R5: With loopback off, msr bit 4 = !cts_n, bit 5 = !dsr_n, bit 6 = !ri_n and bit 7 = !dcd_n, each one clock after the pin.
- R6: msr bit 0 (clear to send), bit 1 (data set ready) and bit 3 (carrier) are set by any change of the matching status, and bit 2 only when ring goes from asserted to deasserted. They stay set until a cycle with msr_rd high clears them. A change seen in that same cycle keeps its bit set.
- R7: ext_rst is high while hw_rst is high, or while enh_en and mcr bit 2 are both 1. The software reset changes no register of the block.
- R8: pwr_down is high exactly when enh_en and mcr bit 7 are both 1, and entering or leaving power-down keeps the stored control byte.
- R9: With enh_en low, mcr bits 2 and 7 are stored but drive neither ext_rst nor pwr_down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst | input | 1 | Hardware reset, active high, asynchronous |
| enh_en | input | 1 | Enhanced-feature enable from the interrupt enable register |
| mcr_wr | input | 1 | Write strobe for the modem control register |
| mcr_wdata | input | 8 | Write data |
| msr_rd | input | 1 | Modem status read strobe; clears the change flags |
| tsr_sout | input | 1 | Serial output of the transmit shifter |
| rx_pin | input | 1 | External serial input |
| cts_n | input | 1 | Clear-to-send input, active low |
| dsr_n | input | 1 | Data-set-ready input, active low |
| ri_n | input | 1 | Ring input, active low |
| dcd_n | input | 1 | Carrier-detect input, active low |
| tx_pin | output | 1 | External serial output |
| rts_n | output | 1 | Request-to-send output, active low |
| dtr_n | output | 1 | Terminal-ready output, active low |
| rx_sin | output | 1 | Serial input to the receive shifter |
| ext_rst | output | 1 | Reset for an external device |
| pwr_down | output | 1 | Power-down request |
| mcr_q | output | 8 | Stored control byte |
| msr | output | 8 | Modem status byte |

## Verification
The bench sets the status from mcr bits in an asymmetric pattern while holding every external status pin asserted. A design that swapped the loopback cross-wiring, or that still listened to the pins, returns the wrong nibble. Ring is driven through both edges to show that only the trailing edge raises its flag. A design that flagged the leading edge would report a ring change while ring is still active. A status change is made in the same cycle as a read, to catch a design that lets the clear win and loses the event. The enhanced bits are written with the enable both high and low, and the stored byte is compared afterwards. A design that ignored the gate, or that let the software reset clear its own register, shows up there.

// File: rtl/uart_mc_pkg.sv
package uart_mc_pkg;
    localparam int MCR_W    = 8;
    localparam int STAT_N   = 4;
    localparam int B_DTR    = 0;
    localparam int B_RTS    = 1;
    localparam int B_OUT1   = 2;
    localparam int B_OUT2   = 3;
    localparam int B_LOOP   = 4;
    localparam int B_PDN    = 7;
    localparam int S_CTS    = 0;
    localparam int S_DSR    = 1;
    localparam int S_RI     = 2;
    localparam int S_DCD    = 3;

    typedef struct packed {
        logic [MCR_W-1:0] mcr;
    } ctl_state_t;

    typedef struct packed {
        logic [STAT_N-1:0] stat;
        logic [STAT_N-1:0] dlt;
    } sts_state_t;
endpackage

// File: rtl/uart_mc_reg.sv
module uart_mc_reg
    import uart_mc_pkg::*;
(
    input  logic             clk,
    input  logic             hw_rst,
    input  logic             enh_en,
    input  logic             wr,
    input  logic [MCR_W-1:0] wdata,
    output logic [MCR_W-1:0] mcr_q,
    output logic             ext_rst,
    output logic             pwr_down
);
    ctl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) st_d.mcr = wdata;
    end

    always_ff @(posedge clk or posedge hw_rst) begin
        if (hw_rst) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mcr_q    = st_q.mcr;
    assign ext_rst  = hw_rst | (enh_en & st_q.mcr[B_OUT1]);
    assign pwr_down = enh_en & st_q.mcr[B_PDN];

    // R7: the software reset leaves the stored byte untouched
    a_r7_no_self_reset: assert property (@(posedge clk) disable iff (hw_rst)
        (ext_rst && !wr) |=> (mcr_q == $past(mcr_q)));
    // R8: power-down keeps configuration
    a_r8_pd_keeps_cfg: assert property (@(posedge clk) disable iff (hw_rst)
        (pwr_down && !wr) |=> (mcr_q == $past(mcr_q)));
    // R1: reset state
    always @(posedge clk) if (hw_rst) a_r1_reset_clear: assert (mcr_q == '0);
endmodule

// File: rtl/uart_mc_route.sv
module uart_mc_route (
    input  logic loop_en,
    input  logic rts_bit,
    input  logic dtr_bit,
    input  logic tsr_sout,
    input  logic rx_pin,
    output logic tx_pin,
    output logic rts_n,
    output logic dtr_n,
    output logic rx_sin
);
    always_comb begin
        if (loop_en) begin
            tx_pin = 1'b1;
            rts_n  = 1'b1;
            dtr_n  = 1'b1;
            rx_sin = tsr_sout;
        end else begin
            tx_pin = tsr_sout;
            rts_n  = ~rts_bit;
            dtr_n  = ~dtr_bit;
            rx_sin = rx_pin;
        end
    end
endmodule

// File: rtl/uart_mc_status.sv
module uart_mc_status
    import uart_mc_pkg::*;
(
    input  logic              clk,
    input  logic              hw_rst,
    input  logic              loop_en,
    input  logic [STAT_N-1:0] int_src,
    input  logic [STAT_N-1:0] ext_src,
    input  logic              rd,
    output logic [7:0]        msr
);
    sts_state_t st_d, st_q;
    logic [STAT_N-1:0] src;
    logic [STAT_N-1:0] evt;

    assign src = loop_en ? int_src : ext_src;

    always_comb begin
        st_d      = st_q;
        st_d.stat = src;
        for (int i = 0; i < STAT_N; i++) begin
            if (i == S_RI) evt[i] = st_q.stat[i] & ~src[i];
            else           evt[i] = st_q.stat[i] ^ src[i];
        end
        st_d.dlt = (rd ? '0 : st_q.dlt) | evt;
    end

    always_ff @(posedge clk or posedge hw_rst) begin
        if (hw_rst) st_q <= '0;
        else        st_q <= st_d;
    end

    assign msr = {st_q.stat, st_q.dlt};

    // R6: flags are sticky until read
    a_r6_sticky: assert property (@(posedge clk) disable iff (hw_rst)
        (!rd) |=> ((msr[3:0] & $past(msr[3:0])) == $past(msr[3:0])));
    // R6: a read with no change clears all flags
    a_r6_read_clears: assert property (@(posedge clk) disable iff (hw_rst)
        (rd && (src == msr[7:4])) |=> (msr[3:0] == '0));
    // R6: ring flag never rises while ring is still asserted
    a_r6_ring_trailing: assert property (@(posedge clk) disable iff (hw_rst)
        $rose(msr[S_RI]) |-> !msr[4+S_RI]);
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
    import uart_mc_pkg::*;
(
    input  logic        clk,
    input  logic        hw_rst,
    input  logic        enh_en,
    input  logic        mcr_wr,
    input  logic [7:0]  mcr_wdata,
    input  logic        msr_rd,
    input  logic        tsr_sout,
    input  logic        rx_pin,
    input  logic        cts_n,
    input  logic        dsr_n,
    input  logic        ri_n,
    input  logic        dcd_n,
    output logic        tx_pin,
    output logic        rts_n,
    output logic        dtr_n,
    output logic        rx_sin,
    output logic        ext_rst,
    output logic        pwr_down,
    output logic [7:0]  mcr_q,
    output logic [7:0]  msr
);
    logic              loop_en;
    logic [STAT_N-1:0] int_src, ext_src;

    uart_mc_reg u_reg (
        .clk(clk), .hw_rst(hw_rst), .enh_en(enh_en), .wr(mcr_wr),
        .wdata(mcr_wdata), .mcr_q(mcr_q), .ext_rst(ext_rst), .pwr_down(pwr_down)
    );

    assign loop_en = mcr_q[B_LOOP];

    uart_mc_route u_route (
        .loop_en(loop_en), .rts_bit(mcr_q[B_RTS]), .dtr_bit(mcr_q[B_DTR]),
        .tsr_sout(tsr_sout), .rx_pin(rx_pin), .tx_pin(tx_pin),
        .rts_n(rts_n), .dtr_n(dtr_n), .rx_sin(rx_sin)
    );

    always_comb begin
        int_src        = '0;
        int_src[S_CTS] = mcr_q[B_RTS];
        int_src[S_DSR] = mcr_q[B_DTR];
        int_src[S_RI]  = mcr_q[B_OUT1];
        int_src[S_DCD] = mcr_q[B_OUT2];
        ext_src        = '0;
        ext_src[S_CTS] = ~cts_n;
        ext_src[S_DSR] = ~dsr_n;
        ext_src[S_RI]  = ~ri_n;
        ext_src[S_DCD] = ~dcd_n;
    end

    uart_mc_status u_sts (
        .clk(clk), .hw_rst(hw_rst), .loop_en(loop_en), .int_src(int_src),
        .ext_src(ext_src), .rd(msr_rd), .msr(msr)
    );

    // R3: loopback parks the line and modem outputs
    a_r3_loop_parks: assert property (@(posedge clk) disable iff (hw_rst)
        mcr_q[B_LOOP] |-> (tx_pin && rts_n && dtr_n && (rx_sin == tsr_sout)));
    // R4: status mirrors control bits one cycle later in loopback
    a_r4_loop_mirror: assert property (@(posedge clk) disable iff (hw_rst)
        $past(mcr_q[B_LOOP]) |-> (msr[7:4] == {$past(mcr_q[B_OUT2]), $past(mcr_q[B_OUT1]),
                                              $past(mcr_q[B_DTR]), $past(mcr_q[B_RTS])}));
    // R1: modem outputs released during reset
    always @(posedge clk) if (hw_rst) a_r1_reset_outs: assert (rts_n && dtr_n && ext_rst);
endmodule

// File: tb/uart_modem_ctl_tb.sv
module uart_modem_ctl_tb;
    logic clk = 1'b0;
    logic hw_rst = 1'b1, enh_en = 1'b0, mcr_wr = 1'b0, msr_rd = 1'b0;
    logic [7:0] mcr_wdata = '0;
    logic tsr_sout = 1'b1, rx_pin = 1'b1;
    logic cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
    logic tx_pin, rts_n, dtr_n, rx_sin, ext_rst, pwr_down;
    logic [7:0] mcr_q, msr;
    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_modem_ctl u_dut (
        .clk(clk), .hw_rst(hw_rst), .enh_en(enh_en), .mcr_wr(mcr_wr),
        .mcr_wdata(mcr_wdata), .msr_rd(msr_rd), .tsr_sout(tsr_sout), .rx_pin(rx_pin),
        .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n), .tx_pin(tx_pin),
        .rts_n(rts_n), .dtr_n(dtr_n), .rx_sin(rx_sin), .ext_rst(ext_rst),
        .pwr_down(pwr_down), .mcr_q(mcr_q), .msr(msr)
    );

    // {mcr, enh, tsr, rx, exp tx, rts_n, dtr_n, rx_sin, ext_rst, pwr_down}
    localparam logic [16:0] VEC [9] = '{
        {8'h00, 3'b001, 6'b011100},
        {8'h03, 3'b010, 6'b100000},
        {8'h02, 3'b001, 6'b001100},
        {8'h13, 3'b001, 6'b111000},
        {8'h10, 3'b010, 6'b111100},
        {8'h84, 3'b011, 6'b111100},
        {8'h84, 3'b100, 6'b011011},
        {8'h04, 3'b111, 6'b111110},
        {8'h80, 3'b101, 6'b011101}
    };

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] v);
        @(negedge clk); mcr_wr = 1'b1; mcr_wdata = v;
        @(negedge clk); mcr_wr = 1'b0;
    endtask

    task automatic rd_clear();
        @(negedge clk); msr_rd = 1'b1;
        @(negedge clk); msr_rd = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ext_rst in reset", {7'd0, ext_rst}, 8'h01);
        hw_rst = 1'b0;
        @(negedge clk);
        chk("R1 mcr reset", mcr_q, 8'h00);
        chk("R1 rts_n/dtr_n reset", {6'd0, rts_n, dtr_n}, 8'h03);
        chk("R1 msr reset", msr, 8'h00);

        foreach (VEC[i]) begin
            enh_en   = VEC[i][8];
            tsr_sout = VEC[i][7];
            rx_pin   = VEC[i][6];
            wr(VEC[i][16:9]);
            chk("R1 stored byte", mcr_q, VEC[i][16:9]);
            chk("R2/R3 tx,rts_n,dtr_n,rx_sin", {4'd0, tx_pin, rts_n, dtr_n, rx_sin},
                {4'd0, VEC[i][5:2]});
            chk("R7/R8/R9 ext_rst,pwr_down", {6'd0, ext_rst, pwr_down}, {6'd0, VEC[i][1:0]});
        end

        // R7/R8: enable off, stored byte kept
        enh_en = 1'b0;
        @(negedge clk);
        chk("R9 enh off keeps mcr", mcr_q, 8'h80);
        chk("R8 pwr_down off", {7'd0, pwr_down}, 8'h00);

        wr(8'h00);
        @(negedge clk);
        rd_clear();
        chk("R6 cleared after read", msr, 8'h00);

        // R5/R6 clear-to-send
        cts_n = 1'b0;
        @(negedge clk);
        chk("R5 cts status + R6 delta", msr, 8'h11);
        rd_clear();
        chk("R6 read clears delta", msr, 8'h10);
        @(negedge clk);
        chk("R6 stays clear", msr, 8'h10);

        // R6 change in the read cycle keeps its flag
        @(negedge clk); msr_rd = 1'b1; dsr_n = 1'b0;
        @(negedge clk); msr_rd = 1'b0;
        chk("R6 change beats read", msr, 8'h32);
        rd_clear();

        // R6 ring: leading edge no flag, trailing edge flag
        ri_n = 1'b0;
        @(negedge clk);
        chk("R6 ring leading no flag", msr, 8'h70);
        ri_n = 1'b1;
        @(negedge clk);
        chk("R6 ring trailing flag", msr, 8'h34);
        rd_clear();
        dcd_n = 1'b0;
        @(negedge clk);
        chk("R5/R6 carrier", msr, 8'hB8);
        rd_clear();

        // R4 loopback: externals all asserted, internal pattern 0101
        ri_n = 1'b0;
        @(negedge clk);
        rd_clear();
        wr(8'h16);
        @(negedge clk);
        chk("R4 loop status nibble", {4'd0, msr[7:4]}, 8'h05);
        rd_clear();
        cts_n = 1'b1; dsr_n = 1'b1; ri_n = 1'b1; dcd_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R4 external ignored", msr, 8'h50);
        chk("R3 loop outputs", {5'd0, tx_pin, rts_n, dtr_n}, 8'h07);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule